// File: doc/BRIEF.md
# Packet Configuration Port

This block terminates a single 30-bit packet stream that carries three kinds of traffic: register reads, register writes and spike events. Packets arrive on a four-phase request/acknowledge input channel and results leave on a four-phase output channel of the same width. The two most significant packet bits choose the kind. A write stores its payload in a small register bank. A read returns a register value. A spike is passed through unchanged, but only while the spike-enable bit of register 0 is set.

A loopback input makes the block echo every accepted packet unchanged to the output before anything else. When loopback is on, a read reply or forwarded spike follows only after the consumer has acknowledged the echo and released its acknowledge. Registers 1 and 2 drive a pair of one-hot monitor selectors, 4 column lines and 8 row lines, that point at one neuron of an array.

Control is a five-state output machine:
- S_IDLE: waiting for a packet.
- S_ECHO: presenting the loopback copy.
- S_ECHO_REL: waiting for the consumer's acknowledge to drop after the echo.
- S_REPLY: presenting the read value or the spike.
- S_REPLY_REL: waiting for the acknowledge to drop after the reply.

The transitions are:
- accept: S_IDLE to S_ECHO, S_REPLY or S_IDLE.
- take: S_ECHO to S_ECHO_REL, and S_REPLY to S_REPLY_REL, on acknowledge high.
- release: S_ECHO_REL to S_REPLY or S_IDLE, and S_REPLY_REL to S_IDLE, on acknowledge low.

Top module: `pkt_cfg_if`

## Requirements
- R1: Synchronous active-high reset clears every register to 0. It also drives `in_ack`, `out_req`, all of `mon_x` and all of `mon_y` low.
- R2: In S_IDLE with `in_ack` low, a high `in_req` is accepted at the next clock edge and `in_ack` rises there. `in_ack` falls at the first edge at which `in_req` is low.
- R3: A packet with bits [29:28] = 2'b10 is a read of the address in bits [5:0]. The reply is that register's value, zero-extended to 30 bits. Addresses at or above the register count read as 0.
- R4: A packet with bits [29:28] = 2'b11 writes bits [27:6] into the register at the address in bits [5:0]. The write takes effect at the accepting edge. Apart from a loopback echo, a write produces no output packet.
- R5: A packet with bit 29 = 0 is a spike. It is forwarded unchanged when bit 0 of register 0 is 1. When that bit is 0, the spike is acknowledged and dropped with no output.
- R6: With `loopback_en` high at acceptance, the packet is first presented unchanged. Any read reply or forwarded spike is presented only after the echo's acknowledge has risen and fallen.
- R7: While `out_req` is high and `out_ack` is low, `out_req` stays high and `out_data` stays constant. `out_req` falls at the edge after `out_ack` is seen high. The next output waits until `out_ack` is low.
- R8: No input is accepted while an output packet is pending, so `in_ack` stays low until the output machine is back in S_IDLE.
- R9: If bit 0 of register 1 is 0, every monitor line is low. If it is 1, exactly one line of `mon_x` is high, at the index in register 2 bits [1:0], and exactly one line of `mon_y` is high, at the index in register 2 bits [4:2]. The lines change at the same edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loopback_en | input | 1 | Echo each accepted packet before its reply |
| in_data | input | 30 | Input packet |
| in_req | input | 1 | Input request |
| in_ack | output | 1 | Input acknowledge |
| out_data | output | 30 | Output packet, 0 when idle |
| out_req | output | 1 | Output request |
| out_ack | input | 1 | Output acknowledge from the consumer |
| mon_x | output | 4 | One-hot monitor column select |
| mon_y | output | 8 | One-hot monitor row select |

## Verification
These timings are counted from the edge that samples `in_req` high in S_IDLE:
- `in_ack` and the register and monitor updates appear after one edge.
- The first output packet, either the echo or the direct reply, also appears after one edge.
- A reply that follows an echo appears one edge after the consumer drops its acknowledge.

The bench drives inputs on falling edges and samples on the next falling edge. It checks `in_ack` and the monitor lines exactly one edge after a request. The consumer process compares each presented packet, in order, against a queue of expected packets and checks that `out_req` drops one edge after it acknowledges.

// File: rtl/pkt_cfg_pkg.sv
package pkt_cfg_pkg;

    typedef enum logic [1:0] {
        K_SPIKE = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2
    } pkt_kind_e;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_ECHO      = 3'd1,
        S_ECHO_REL  = 3'd2,
        S_REPLY     = 3'd3,
        S_REPLY_REL = 3'd4
    } out_state_e;

endpackage

// File: rtl/pkt_cfg_decode.sv
module pkt_cfg_decode
    import pkt_cfg_pkg::*;
#(
    parameter int PKT_W  = 30,
    parameter int ADDR_W = 6,
    localparam int DATA_W = PKT_W - 2 - ADDR_W
) (
    input  logic [PKT_W-1:0]  pkt,
    output pkt_kind_e         kind,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);

    always_comb begin
        unique case (pkt[PKT_W-1 -: 2])
            2'b10:   kind = K_READ;
            2'b11:   kind = K_WRITE;
            default: kind = K_SPIKE;
        endcase
        addr  = pkt[ADDR_W-1:0];
        wdata = pkt[PKT_W-3:ADDR_W];
    end

endmodule

// File: rtl/pkt_cfg_regfile.sv
module pkt_cfg_regfile #(
    parameter int NREGS  = 4,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 22,
    parameter int SEL_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              spike_en,
    output logic              tgt_en,
    output logic [SEL_W-1:0]  tgt_sel
);

    logic [DATA_W-1:0] bank [NREGS];

    for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[gi] <= '0;
            end else if (we && addr == ADDR_W'(gi)) begin
                bank[gi] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata = bank[i];
            end
        end
    end

    assign spike_en = bank[0][0];
    assign tgt_en   = bank[1][0];
    assign tgt_sel  = bank[2][SEL_W-1:0];

endmodule

// File: rtl/pkt_cfg_monitor.sv
module pkt_cfg_monitor #(
    parameter int MON_X = 4,
    parameter int MON_Y = 8,
    localparam int XW = $clog2(MON_X),
    localparam int YW = $clog2(MON_Y)
) (
    input  logic             en,
    input  logic [XW+YW-1:0] sel,
    output logic [MON_X-1:0] mon_x,
    output logic [MON_Y-1:0] mon_y
);

    for (genvar gx = 0; gx < MON_X; gx++) begin : g_col
        assign mon_x[gx] = en && (sel[XW-1:0] == XW'(gx));
    end

    for (genvar gy = 0; gy < MON_Y; gy++) begin : g_row
        assign mon_y[gy] = en && (sel[XW+YW-1:XW] == YW'(gy));
    end

endmodule

// File: rtl/pkt_cfg_ctrl.sv
module pkt_cfg_ctrl
    import pkt_cfg_pkg::*;
#(
    parameter int PKT_W  = 30,
    parameter int DATA_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loopback_en,
    input  logic [PKT_W-1:0]  in_data,
    input  logic              in_req,
    input  pkt_kind_e         kind,
    input  logic [DATA_W-1:0] rdata,
    input  logic              spike_en,
    input  logic              out_ack,
    output logic              in_ack,
    output logic              we,
    output logic [PKT_W-1:0]  out_data,
    output logic              out_req
);

    out_state_e       state, state_nx;
    logic             in_ack_q;
    logic [PKT_W-1:0] echo_q;
    logic [PKT_W-1:0] reply_q;
    logic             need_reply_q;

    logic             accept;
    logic             need_reply;
    logic [PKT_W-1:0] reply_val;

    assign accept     = (state == S_IDLE) && in_req && !in_ack_q;
    assign need_reply = (kind == K_READ) || (kind == K_SPIKE && spike_en);
    assign reply_val  = (kind == K_READ) ? PKT_W'(rdata) : in_data;
    assign we         = accept && (kind == K_WRITE);
    assign in_ack     = in_ack_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    if (loopback_en)     state_nx = S_ECHO;
                    else if (need_reply) state_nx = S_REPLY;
                end
            end
            S_ECHO:      if (out_ack)  state_nx = S_ECHO_REL;
            S_ECHO_REL:  if (!out_ack) state_nx = need_reply_q ? S_REPLY : S_IDLE;
            S_REPLY:     if (out_ack)  state_nx = S_REPLY_REL;
            S_REPLY_REL: if (!out_ack) state_nx = S_IDLE;
            default:                   state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_IDLE;
            in_ack_q     <= 1'b0;
            echo_q       <= '0;
            reply_q      <= '0;
            need_reply_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                in_ack_q     <= 1'b1;
                echo_q       <= in_data;
                reply_q      <= reply_val;
                need_reply_q <= need_reply;
            end else if (!in_req) begin
                in_ack_q <= 1'b0;
            end
        end
    end

    always_comb begin
        out_req  = 1'b0;
        out_data = '0;
        unique case (state)
            S_ECHO: begin
                out_req  = 1'b1;
                out_data = echo_q;
            end
            S_REPLY: begin
                out_req  = 1'b1;
                out_data = reply_q;
            end
            default: begin
                out_req  = 1'b0;
                out_data = '0;
            end
        endcase
    end

endmodule

// File: rtl/pkt_cfg_if.sv
module pkt_cfg_if
    import pkt_cfg_pkg::*;
#(
    parameter int PKT_W  = 30,
    parameter int ADDR_W = 6,
    parameter int NREGS  = 4,
    parameter int MON_X  = 4,
    parameter int MON_Y  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             loopback_en,
    input  logic [PKT_W-1:0] in_data,
    input  logic             in_req,
    output logic             in_ack,
    output logic [PKT_W-1:0] out_data,
    output logic             out_req,
    input  logic             out_ack,
    output logic [MON_X-1:0] mon_x,
    output logic [MON_Y-1:0] mon_y
);

    localparam int DATA_W = PKT_W - 2 - ADDR_W;
    localparam int SEL_W  = $clog2(MON_X) + $clog2(MON_Y);

    pkt_kind_e         kind;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic              we;
    logic              spike_en;
    logic              tgt_en;
    logic [SEL_W-1:0]  tgt_sel;

    pkt_cfg_decode #(.PKT_W(PKT_W), .ADDR_W(ADDR_W)) u_dec (
        .pkt   (in_data),
        .kind  (kind),
        .addr  (addr),
        .wdata (wdata)
    );

    pkt_cfg_regfile #(
        .NREGS(NREGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (we),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .spike_en (spike_en),
        .tgt_en   (tgt_en),
        .tgt_sel  (tgt_sel)
    );

    pkt_cfg_ctrl #(.PKT_W(PKT_W), .DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .loopback_en (loopback_en),
        .in_data     (in_data),
        .in_req      (in_req),
        .kind        (kind),
        .rdata       (rdata),
        .spike_en    (spike_en),
        .out_ack     (out_ack),
        .in_ack      (in_ack),
        .we          (we),
        .out_data    (out_data),
        .out_req     (out_req)
    );

    pkt_cfg_monitor #(.MON_X(MON_X), .MON_Y(MON_Y)) u_mon (
        .en    (tgt_en),
        .sel   (tgt_sel),
        .mon_x (mon_x),
        .mon_y (mon_y)
    );

endmodule

// File: rtl/pkt_cfg_checker.sv
module pkt_cfg_checker #(
    parameter int PKT_W = 30,
    parameter int MON_X = 4,
    parameter int MON_Y = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_req,
    input logic             in_ack,
    input logic [PKT_W-1:0] out_data,
    input logic             out_req,
    input logic             out_ack,
    input logic [MON_X-1:0] mon_x,
    input logic [MON_Y-1:0] mon_y
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!in_ack && !out_req && mon_x == '0 && mon_y == '0));

    a_r2_ack_release: assert property (@(posedge clk) disable iff (rst)
        (in_ack && !in_req) |=> !in_ack);

    a_r7_hold_data: assert property (@(posedge clk) disable iff (rst)
        (out_req && !out_ack) |=> (out_req && $stable(out_data)));

    a_r7_drop_req: assert property (@(posedge clk) disable iff (rst)
        (out_req && out_ack) |=> !out_req);

    a_r8_no_accept: assert property (@(posedge clk) disable iff (rst)
        (out_req && !in_ack) |=> !in_ack);

    a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
        ($onehot0(mon_x) && $onehot0(mon_y) && ($countones(mon_x) == $countones(mon_y))));

endmodule

bind pkt_cfg_if pkt_cfg_checker #(.PKT_W(PKT_W), .MON_X(MON_X), .MON_Y(MON_Y)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_req   (in_req),
    .in_ack   (in_ack),
    .out_data (out_data),
    .out_req  (out_req),
    .out_ack  (out_ack),
    .mon_x    (mon_x),
    .mon_y    (mon_y)
);

// File: tb/pkt_cfg_if_bench.sv
`timescale 1ns/1ps
module pkt_cfg_if_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        loopback_en = 1'b0;
    logic [29:0] in_data = '0;
    logic        in_req = 1'b0;
    logic        in_ack;
    logic [29:0] out_data;
    logic        out_req;
    logic        out_ack = 1'b0;
    logic [3:0]  mon_x;
    logic [7:0]  mon_y;

    int checks = 0;
    int failures = 0;
    bit stall = 1'b0;
    logic [29:0] expq [$];

    always #4 clk = ~clk;

    pkt_cfg_if u_pkt_cfg_if (
        .clk(clk), .rst(rst), .loopback_en(loopback_en),
        .in_data(in_data), .in_req(in_req), .in_ack(in_ack),
        .out_data(out_data), .out_req(out_req), .out_ack(out_ack),
        .mon_x(mon_x), .mon_y(mon_y)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [29:0] rd_pkt(input logic [5:0] a);
        return {2'b10, 22'd0, a};
    endfunction

    function automatic logic [29:0] wr_pkt(input logic [5:0] a, input logic [21:0] d);
        return {2'b11, d, a};
    endfunction

    // Consumer: compares presented packets against the expected queue (R3 R5 R6 R7)
    initial begin
        forever begin
            @(negedge clk);
            if (out_req && !out_ack && !stall) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R4 unexpected output", {2'b0, out_data}, 32'h0);
                end else begin
                    logic [29:0] e;
                    e = expq.pop_front();
                    check(out_data == e, "R6 output order/value", {2'b0, out_data}, {2'b0, e});
                end
                out_ack = 1'b1;
                @(negedge clk);
                check(!out_req, "R7 req drop after ack", {31'b0, out_req}, 32'h0);
                out_ack = 1'b0;
            end
        end
    end

    task automatic send(input logic [29:0] p, input string tag);
        @(negedge clk);
        in_data = p;
        in_req  = 1'b1;
        @(negedge clk);
        check(in_ack, {tag, " R2 ack after one edge"}, {31'b0, in_ack}, 32'h1);
        in_req = 1'b0;
        @(negedge clk);
        check(!in_ack, "R2 ack release", {31'b0, in_ack}, 32'h0);
    endtask

    task automatic drain();
        int n = 0;
        while ((expq.size() != 0 || out_req || out_ack) && n < 100) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R6 all expected outputs seen", expq.size(), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!in_ack && !out_req, "R1 reset handshake", {30'b0, in_ack, out_req}, 32'h0);
        check(mon_x == 0 && mon_y == 0, "R1 reset monitor", {20'b0, mon_x, mon_y}, 32'h0);

        // R6 + R1: loopback echo then reset value of register 0
        loopback_en = 1'b1;
        expq.push_back(rd_pkt(6'd0));
        expq.push_back(30'd0);
        send(rd_pkt(6'd0), "R6 read reg0");
        drain();
        loopback_en = 1'b0;

        // R4: write produces no output
        send(wr_pkt(6'd0, 22'd255), "R4 write reg0");
        repeat (4) begin
            @(negedge clk);
            check(!out_req, "R4 write silent", {31'b0, out_req}, 32'h0);
        end

        // R5: spike forwarded when enabled
        expq.push_back(30'd8);
        send(30'd8, "R5 spike fwd");
        drain();

        // R3: read back written value
        expq.push_back(30'd255);
        send(rd_pkt(6'd0), "R3 read reg0");
        drain();

        // R5: spike dropped when disabled
        send(wr_pkt(6'd0, 22'd0), "R4 clear reg0");
        send(30'd8, "R5 spike drop");
        repeat (5) begin
            @(negedge clk);
            check(!out_req, "R5 spike dropped", {31'b0, out_req}, 32'h0);
        end

        // R9: monitor decode
        send(wr_pkt(6'd1, 22'd3), "R9 enable");
        check(mon_x == 4'b0001 && mon_y == 8'h01, "R9 sel zero", {20'b0, mon_x, mon_y}, 32'h101);
        @(negedge clk);
        in_data = wr_pkt(6'd2, 22'd511);
        in_req = 1'b1;
        @(negedge clk);
        check(mon_x == 4'b1000 && mon_y == 8'h80, "R9 update with ack", {20'b0, mon_x, mon_y}, 32'h880);
        in_req = 1'b0;
        @(negedge clk);
        send(wr_pkt(6'd2, 22'd6), "R9 sel 6");
        check(mon_x == 4'b0100 && mon_y == 8'h02, "R9 sel 6", {20'b0, mon_x, mon_y}, 32'h402);
        send(wr_pkt(6'd1, 22'd0), "R9 disable");
        check(mon_x == 0 && mon_y == 0, "R9 disabled", {20'b0, mon_x, mon_y}, 32'h0);
        send(wr_pkt(6'd2, 22'd511), "R4 reg2");

        // R3: out-of-range address and register 2
        expq.push_back(30'd0);
        send(rd_pkt(6'd40), "R3 out of range");
        drain();
        expq.push_back(30'd511);
        send(rd_pkt(6'd2), "R3 read reg2");
        drain();

        // R8 + R7: stalled consumer blocks new input, data stays put
        send(wr_pkt(6'd0, 22'd1), "R4 spike enable");
        loopback_en = 1'b1;
        stall = 1'b1;
        expq.push_back(rd_pkt(6'd2));
        expq.push_back(30'd511);
        expq.push_back(30'd12);
        expq.push_back(30'd12);
        send(rd_pkt(6'd2), "R8 first");
        in_data = 30'd12;
        in_req = 1'b1;
        repeat (6) begin
            @(negedge clk);
            check(!in_ack, "R8 blocked", {31'b0, in_ack}, 32'h0);
            check(out_req && out_data == rd_pkt(6'd2), "R7 stable while stalled", {2'b0, out_data}, {2'b0, rd_pkt(6'd2)});
        end
        stall = 1'b0;
        begin
            int n = 0;
            while (!in_ack && n < 50) begin
                @(negedge clk);
                n++;
            end
        end
        check(in_ack, "R8 accepted after drain", {31'b0, in_ack}, 32'h1);
        in_req = 1'b0;
        drain();
        loopback_en = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule